// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable functional model of an asynchronous static memory. Each word holds two byte lanes. There is no clock. Five active-low controls govern the array: a chip select, a write strobe, an output enable and one enable per byte lane. A read presents the addressed word through combinational logic. A write is captured when the write condition ends.

The bidirectional data bus of a real part is split into three vectors: a data-in vector, a data-out vector and a per-lane drive vector. This lets the model be simulated and synthesized without tristate primitives. A board-level wrapper can rebuild the shared bus from the drive vector. A standby output reports when the chip is deselected. The write-capture point is the rising edge of the OR of chip select and write strobe. Either control can therefore open and close a write. The data is committed by whichever of the two is released first.

The address width is a parameter. The full organization of 131072 sixteen-bit words needs an address width of 17. The default is smaller so that the default build stays light.

Top module: `sram_byte_lane`

## Requirements
- R1: While `cs_n` is 1, `standby` is 1, `lane_drive` is 0 and `rd_data` is 0, whatever the other controls are.
- R2: While `cs_n` is 0, `standby` is 0.
- R3: A write commits on the rising edge of (`cs_n` OR `wr_n`). At that edge, `wr_data` and `addr` are sampled. A lane is updated only if its enable is 0: `lane_en_n[0]` selects bits 7:0 and `lane_en_n[1]` selects bits 15:8.
- R4: The commit happens when the first of `cs_n` and `wr_n` returns high. A change on `wr_data` after that point, while the other control is still low, leaves the stored word unchanged.
- R5: With `cs_n`=0, `wr_n`=1 and `out_en_n`=0, each lane whose enable is 0 has its `lane_drive` bit set to 1 and shows the stored byte on `rd_data`. A lane whose enable is 1 stays undriven.
- R6: With `cs_n`=0, `wr_n`=1 and `out_en_n`=1, both `lane_drive` bits are 0.
- R7: While `wr_n` is 0, both `lane_drive` bits are 0, even when `out_en_n` is 0.
- R8: With the chip selected and both lane enables at 1, a read drives neither lane and a write changes no stored bit.
- R9: Any lane whose `lane_drive` bit is 0 reads as zero on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*LANE_W | Data to be written |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| lane_en_n | input | LANES | Per-lane enables, active low; bit 0 is the low byte |
| rd_data | output | LANES*LANE_W | Read data; undriven lanes are zero |
| lane_drive | output | LANES | Per-lane output drive |
| standby | output | 1 | High while the chip is deselected |

## Verification
Every one of the 32 settings of the five controls is applied twice, at different addresses, with fresh data. Each setting is compared against a word-level reference array. This sweep separates read, output-disable, write and standby, and tells apart the single-lane, both-lane and no-lane cases. Each write setting is closed by releasing the write strobe first on half the settings and the chip select first on the other half. The data is then corrupted before the second release. A readback afterwards shows whether the capture came from the first release and whether the disabled lanes kept their old contents.

// File: rtl/sram_pkg.sv
package sram_pkg;

   // Operating condition decoded from the control pins
   typedef enum logic [1:0] {
      SM_STANDBY = 2'd0,
      SM_OUT_OFF = 2'd1,
      SM_READ    = 2'd2,
      SM_WRITE   = 2'd3
   } sram_mode_e;

   function automatic sram_mode_e decode_mode(input logic cs_n,
                                              input logic wr_n,
                                              input logic oe_n);
      if (cs_n)       return SM_STANDBY;
      else if (!wr_n) return SM_WRITE;
      else if (!oe_n) return SM_READ;
      else            return SM_OUT_OFF;
   endfunction

endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
   import sram_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic             out_en_n,
   input  logic [LANES-1:0] lane_en_n,
   output logic [LANES-1:0] lane_rd,
   output logic [LANES-1:0] lane_wr,
   output logic             commit_clk,
   output logic             deselected
);

   sram_mode_e mode;

   always_comb begin
      mode       = decode_mode(cs_n, wr_n, out_en_n);
      deselected = (mode == SM_STANDBY);
      commit_clk = cs_n | wr_n;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane_ctl
      always_comb begin
         lane_rd[g] = (mode == SM_READ) && !lane_en_n[g];
         lane_wr[g] = !lane_en_n[g];
      end
   end

   always_comb begin
      if (!$isunknown({cs_n, wr_n, out_en_n, lane_en_n})) begin
         // R7
         write_no_drive_chk: assert (wr_n || lane_rd == '0)
            else $error("lane driven during write strobe");
         // R6
         oe_off_no_drive_chk: assert (!out_en_n || lane_rd == '0)
            else $error("lane driven with output enable inactive");
      end
   end

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 8
) (
   input  logic              commit_clk,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] cells [DEPTH];

   // Capture on the release edge of the write condition
   always_ff @(posedge commit_clk) begin
      if (wr_sel) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
   parameter int LANE_W     = 8,
   parameter bit UNDRV_ZERO = 1'b1
) (
   input  logic              drive,
   input  logic [LANE_W-1:0] stored,
   output logic [LANE_W-1:0] lane_out
);

   if (UNDRV_ZERO) begin : g_zero
      assign lane_out = drive ? stored : '0;
      always_comb begin
         if (!$isunknown(drive)) begin
            // R9
            undriven_zero_chk: assert (drive || lane_out == '0)
               else $error("undriven lane not zero");
         end
      end
   end else begin : g_pass
      assign lane_out = stored;
   end

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
   parameter int ADDR_W     = 10,
   parameter int LANE_W     = 8,
   parameter int LANES      = 2,
   parameter bit UNDRV_ZERO = 1'b1
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic                    cs_n,
   input  logic                    wr_n,
   input  logic                    out_en_n,
   input  logic [LANES-1:0]        lane_en_n,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic [LANES-1:0]        lane_drive,
   output logic                    standby
);

   localparam int WORD_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("ADDR_W out of range 1..24");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("LANE_W must be positive");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be positive");
   end

   logic [LANES-1:0] lane_rd;
   logic [LANES-1:0] lane_wr;
   logic             commit_clk;
   logic             deselected;

   sram_ctl_decode #(.LANES(LANES)) u_dec (
      .cs_n       (cs_n),
      .wr_n       (wr_n),
      .out_en_n   (out_en_n),
      .lane_en_n  (lane_en_n),
      .lane_rd    (lane_rd),
      .lane_wr    (lane_wr),
      .commit_clk (commit_clk),
      .deselected (deselected)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] stored;

      sram_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
         .commit_clk (commit_clk),
         .wr_sel     (lane_wr[l]),
         .addr       (addr),
         .wdata      (wr_data[l*LANE_W +: LANE_W]),
         .rdata      (stored)
      );

      sram_lane_gate #(.LANE_W(LANE_W), .UNDRV_ZERO(UNDRV_ZERO)) u_gate (
         .drive    (lane_rd[l]),
         .stored   (stored),
         .lane_out (rd_data[l*LANE_W +: LANE_W])
      );

      always_comb begin
         if (!$isunknown({lane_en_n[l], lane_rd[l]})) begin
            // R8
            lane_off_quiet_chk: assert (!lane_en_n[l] || !lane_rd[l])
               else $error("disabled lane is driving");
         end
      end
   end

   assign lane_drive = lane_rd;
   assign standby    = deselected;

   always_comb begin
      if (!$isunknown({cs_n, standby, lane_drive})) begin
         // R1
         standby_quiet_chk: assert (!standby || lane_drive == '0)
            else $error("drive while in standby");
         // R2
         standby_sel_chk: assert (standby == cs_n)
            else $error("standby flag disagrees with chip select");
      end
      if (!$isunknown({cs_n, rd_data}) && UNDRV_ZERO) begin
         // R1
         standby_data_chk: assert (!cs_n || rd_data == {WORD_W{1'b0}})
            else $error("data present while deselected");
      end
   end

endmodule

// File: tb/sim_sram_byte_lane.sv
module sim_sram_byte_lane;

   localparam int AW = 4;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [15:0]   wr_data = '0;
   logic          cs_n = 1'b1, wr_n = 1'b1, out_en_n = 1'b1;
   logic [1:0]    lane_en_n = 2'b11;
   logic [15:0]   rd_data;
   logic [1:0]    lane_drive;
   logic          standby;

   logic [15:0] ref_mem [NW];
   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sram_byte_lane #(.ADDR_W(AW)) u0 (
      .addr(addr), .wr_data(wr_data), .cs_n(cs_n), .wr_n(wr_n),
      .out_en_n(out_en_n), .lane_en_n(lane_en_n),
      .rd_data(rd_data), .lane_drive(lane_drive), .standby(standby)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic readback(input logic [AW-1:0] a, input string req);
      @(negedge clk);
      addr = a; lane_en_n = 2'b00; out_en_n = 1'b0; wr_n = 1'b1; cs_n = 1'b0;
      #1;
      chk(req, {13'd0, standby, lane_drive, rd_data}, {13'd0, 1'b0, 2'b11, ref_mem[a]});
      @(negedge clk);
      cs_n = 1'b1; out_en_n = 1'b1; lane_en_n = 2'b11;
   endtask

   initial begin
      #1;
      // R1: deselected state at start
      chk("R1 idle", {13'd0, standby, lane_drive, rd_data}, {13'd0, 1'b1, 2'b00, 16'h0});

      // R3: fill every word with write-strobe controlled full writes
      for (int a = 0; a < NW; a++) begin
         @(negedge clk);
         addr = AW'(a); wr_data = 16'(a * 16'h1357) ^ 16'hA5C3; lane_en_n = 2'b00;
         wr_n = 1'b0; cs_n = 1'b0;
         @(negedge clk);
         wr_n = 1'b1;
         ref_mem[a] = wr_data;
         #1 cs_n = 1'b1;
      end
      for (int a = 0; a < NW; a++) readback(AW'(a), "R3 fill readback");

      // Sweep all 32 control settings, twice
      for (int p = 0; p < 2; p++) begin
         for (int c = 0; c < 32; c++) begin
            logic [4:0]    cv;
            logic [AW-1:0] a;
            logic [15:0]   d, exp_d;
            logic [1:0]    exp_dr;
            logic          is_wr;
            cv = 5'(c);
            a  = AW'(c + p * 7);
            d  = 16'(p * 16'h1000) ^ 16'(c * 16'h0B1D) ^ 16'h6E2A;
            @(negedge clk);
            addr = a; wr_data = d; lane_en_n = cv[1:0]; out_en_n = cv[2];
            wr_n = cv[3];
            #1 cs_n = cv[4];
            #1;
            for (int l = 0; l < 2; l++) begin
               exp_dr[l] = !cv[4] && cv[3] && !cv[2] && !cv[1+l-1];
               exp_d[l*8 +: 8] = exp_dr[l] ? ref_mem[a][l*8 +: 8] : 8'h00;
            end
            // R1 R2 R5 R6 R7 R8 R9: outputs under this control setting
            chk(cv[4] ? "R1 standby" : (!cv[3] ? "R7 write no drive" :
                (cv[2] ? "R6 output off" : (cv[1:0] == 2'b11 ? "R8 no lane read" : "R5 read R9"))),
                {13'd0, standby, lane_drive, rd_data}, {13'd0, cv[4], exp_dr, exp_d});
            is_wr = !cv[4] && !cv[3];
            // R4: release one control, corrupt data, then release the other
            @(negedge clk);
            if (c % 2 == 0) wr_n = 1'b1; else cs_n = 1'b1;
            #1 wr_data = ~d;
            #1 begin cs_n = 1'b1; wr_n = 1'b1; end
            if (is_wr) begin
               if (!cv[0]) ref_mem[a][7:0]  = d[7:0];
               if (!cv[1]) ref_mem[a][15:8] = d[15:8];
            end
            readback(a, is_wr ? (cv[1:0] == 2'b11 ? "R8 masked write" : "R3 R4 write commit")
                              : "R2 no write");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule